// File: doc/BRIEF.md
# Shared cache region maintenance engine

This block drives maintenance over the second-level cache that several cores share. Software programs a region end address and then writes a region start address. The start write alone launches a walk over every cache line from the line that holds the start address up to and including the line that holds the end address. The walk visits one line per cycle. For each line it presents the line address on a lookup port, and the tag logic answers hit and dirty in the same cycle. Depending on the selected operation, the engine then sends dirty lines out on a write-back stream and tells the cache to mark the line clean or to drop it.

A second trigger register starts a walk over the whole capacity, which invalidates every line. An invalidate-mode bit chooses whether dirty lines are written back first. A busy flag covers every walk. A trigger that arrives while a walk is running is ignored, and a sticky overrun flag records it. A disable bit, which can be changed only while the engine is idle, makes every lookup count as a miss. The line size (64 or 128 bytes) and the capacity are parameters.

Register map: selector 0 is the control register, 1 is region end, 2 is region start and 3 is the whole-cache trigger, which is write-only and reads as 0. The control fields are: bit 0 disable, bit 1 invalidate mode, bit 2 busy (read-only), bit 3 overrun (write 1 to clear) and bits [11:9] operation code. End and start read back as the full value last written.

Top module: `cache_rgn_engine`

## Requirements
- R1: The operation is latched at the trigger. With control bits [11:9] = 001, hit lines are invalidated. Dirty ones are written back first only when invalidate mode (bit 1) is 1. Every other code means flush: dirty hit lines are written back and then marked clean, and no line is invalidated.
- R2: Writing selector 1 only stores the end address and does not set busy. Writing selector 2 while idle stores the start address and starts the walk.
- R3: Address bits below the line size are ignored in both start and end. The walk covers line addresses from the aligned start up to and including the aligned end, in increasing order, one lookup at a time. If the start line is above the end line, only the start line is visited.
- R4: Control bit 2 (busy) reads 1 from the cycle after an accepted trigger through the cycle that processes the last line, and 0 otherwise. While idle, no lookup, write-back or line action is issued.
- R5: Line size is 128 bytes when LINE_CFG is 0 and 64 bytes otherwise. Capacity is 128 KB shifted left by SIZE_CFG. A whole-cache walk lasts capacity/line-size cycles when no write-back stalls.
- R6: Writing selector 3 while idle visits every line of the capacity from address 0 and invalidates every hit line. When invalidate mode is 1, dirty lines are written back first.
- R7: A write to selector 2 or 3 while busy is ignored and sets overrun (control bit 3). The flag stays set until a control write with bit 3 = 1.
- R8: The disable bit changes only on a control write while idle. While it is set, every lookup is treated as a miss: no write-back and no line action take place, but the walk and busy run as usual.
- R9: Write-back is valid/ready. Once wb_valid rises, it stays high with a stable wb_addr until wb_ready is seen. The walk stays on that line meanwhile and otherwise advances one line per cycle.
- R10: act_valid pulses once per hit line that is acted on. act_inv is 1 for invalidate and 0 for mark-clean. For a dirty line that needs write-back, the action comes in the same cycle the write-back is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register selector (0 control, 1 end, 2 start, 3 whole-cache) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data for the selected register, combinational |
| look_valid | output | 1 | Lookup presented (high while busy) |
| look_addr | output | ADDR_W | Line-aligned address being looked up |
| look_hit | input | 1 | Lookup hit, same-cycle answer |
| look_dirty | input | 1 | Hit line is dirty, same-cycle answer |
| act_valid | output | 1 | Apply action to the looked-up line |
| act_inv | output | 1 | 1 = invalidate line, 0 = mark line clean |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | ADDR_W | Line address to write back |

## Verification
The assertions assume the tag side behaves like a real cache. The answer on look_hit and look_dirty depends only on look_addr and on the line state, and that state changes only at a clock edge where act_valid applies to the line. Because of this, a write-back held against back-pressure sees the same answer on every stalled cycle. The bench keeps to this with a cache model whose state arrays are updated only by non-blocking writes on act_valid pulses. It drives wb_ready either always high or pseudo-randomly, and it issues overlapping triggers and disable writes only through the register port.

// File: rtl/cache_rgn_pkg.sv
package cache_rgn_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_END   = 2'd1,
    SEL_START = 2'd2,
    SEL_FULL  = 2'd3
  } reg_sel_e;

  // control register field positions
  localparam int CB_DIS  = 0;
  localparam int CB_IM   = 1;
  localparam int CB_BUSY = 2;
  localparam int CB_OVR  = 3;
  localparam int CB_OPLO = 9;

  typedef struct packed {
    logic inv;          // drop hit lines
    logic flush_first;  // write back dirty hit lines
  } walk_mode_t;

  function automatic walk_mode_t rgn_decode(input logic [2:0] op, input logic im);
    walk_mode_t m;
    m.inv         = (op == 3'b001);
    m.flush_first = (op != 3'b001) || im;
    return m;
  endfunction

endpackage

// File: rtl/cache_rgn_regs.sv
module cache_rgn_regs
  import cache_rgn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  output logic [2:0]        op_q,
  output logic              im_q,
  output logic              dis_q,
  output logic              ovr_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [ADDR_W-1:0] start_q,
  output logic              trig_rgn,
  output logic              trig_full,
  output logic [ADDR_W-1:0] rdata
);

  logic is_trig;

  assign is_trig   = we && (sel == SEL_START || sel == SEL_FULL);
  assign trig_rgn  = we && sel == SEL_START && !busy;
  assign trig_full = we && sel == SEL_FULL && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= '0;
      im_q    <= 1'b0;
      dis_q   <= 1'b0;
      ovr_q   <= 1'b0;
      end_q   <= '0;
      start_q <= '0;
    end else begin
      if (is_trig && busy) ovr_q <= 1'b1;
      if (we) begin
        unique case (sel)
          SEL_CTRL: begin
            op_q <= wdata[CB_OPLO+2:CB_OPLO];
            im_q <= wdata[CB_IM];
            if (!busy) dis_q <= wdata[CB_DIS];
            if (wdata[CB_OVR]) ovr_q <= 1'b0;
          end
          SEL_END:   end_q <= wdata;
          SEL_START: if (!busy) start_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata[CB_OPLO+2:CB_OPLO] = op_q;
        rdata[CB_OVR]            = ovr_q;
        rdata[CB_BUSY]           = busy;
        rdata[CB_IM]             = im_q;
        rdata[CB_DIS]            = dis_q;
      end
      SEL_END:   rdata = end_q;
      SEL_START: rdata = start_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/cache_rgn_walk.sv
module cache_rgn_walk
  import cache_rgn_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_OFF  = 6,
  parameter int NUM_LINES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_rgn,
  input  logic              trig_full,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  walk_mode_t        rgn_mode,
  input  logic              im,
  input  logic              step,
  output logic              busy,
  output walk_mode_t        mode_q,
  output logic [ADDR_W-1:0] line_addr
);

  localparam int LN_W = ADDR_W - LINE_OFF;
  localparam logic [LN_W-1:0] FULL_LAST = LN_W'(NUM_LINES - 1);

  logic [LN_W-1:0] cur_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      mode_q <= '0;
    end else if (!busy) begin
      if (trig_rgn) begin
        busy   <= 1'b1;
        cur_q  <= start_addr[ADDR_W-1:LINE_OFF];
        last_q <= end_addr[ADDR_W-1:LINE_OFF];
        mode_q <= rgn_mode;
      end else if (trig_full) begin
        busy   <= 1'b1;
        cur_q  <= '0;
        last_q <= FULL_LAST;
        mode_q <= '{inv: 1'b1, flush_first: im};
      end
    end else if (step) begin
      if (cur_q >= last_q) busy <= 1'b0;
      else                 cur_q <= cur_q + 1'b1;
    end
  end

  assign line_addr = {cur_q, {LINE_OFF{1'b0}}};

endmodule

// File: rtl/cache_rgn_lineop.sv
module cache_rgn_lineop
  import cache_rgn_pkg::*;
(
  input  logic       busy,
  input  logic       dis,
  input  walk_mode_t mode,
  input  logic       hit_raw,
  input  logic       dirty,
  input  logic       wb_ready,
  output logic       wb_valid,
  output logic       act_valid,
  output logic       act_inv,
  output logic       step
);

  logic hit, need_wb;

  assign hit       = busy && hit_raw && !dis;
  assign need_wb   = hit && dirty && mode.flush_first;
  assign wb_valid  = need_wb;
  assign step      = busy && (!need_wb || wb_ready);
  assign act_valid = step && hit && (mode.inv || need_wb);
  assign act_inv   = mode.inv;

endmodule

// File: rtl/cache_rgn_engine.sv
module cache_rgn_engine
  import cache_rgn_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_CFG = 1,
  parameter int SIZE_CFG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              look_valid,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              look_hit,
  input  logic              look_dirty,
  output logic              act_valid,
  output logic              act_inv,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int LINE_OFF  = (LINE_CFG == 0) ? 7 : 6;
  localparam int CAP_BYTES = 131072 << SIZE_CFG;
  localparam int NUM_LINES = CAP_BYTES >> LINE_OFF;

  logic [2:0]        op_q;
  logic              im_q, dis_q, ovr_q, busy, step, trig_rgn, trig_full;
  logic [ADDR_W-1:0] end_q, start_q;
  walk_mode_t        mode_q;

  cache_rgn_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel_e'(reg_addr)),
    .wdata(reg_wdata), .busy(busy), .op_q(op_q), .im_q(im_q),
    .dis_q(dis_q), .ovr_q(ovr_q), .end_q(end_q), .start_q(start_q),
    .trig_rgn(trig_rgn), .trig_full(trig_full), .rdata(reg_rdata)
  );

  cache_rgn_walk #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .NUM_LINES(NUM_LINES)) u_walk (
    .clk(clk), .rst_n(rst_n), .trig_rgn(trig_rgn), .trig_full(trig_full),
    .start_addr(reg_wdata), .end_addr(end_q),
    .rgn_mode(rgn_decode(op_q, im_q)), .im(im_q), .step(step),
    .busy(busy), .mode_q(mode_q), .line_addr(look_addr)
  );

  cache_rgn_lineop u_op (
    .busy(busy), .dis(dis_q), .mode(mode_q), .hit_raw(look_hit),
    .dirty(look_dirty), .wb_ready(wb_ready), .wb_valid(wb_valid),
    .act_valid(act_valid), .act_inv(act_inv), .step(step)
  );

  assign look_valid = busy;
  assign wb_addr    = look_addr;

endmodule

// File: rtl/cache_rgn_engine_chk.sv
module cache_rgn_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic              busy,
  input logic              dis_q,
  input logic              ovr_q,
  input logic              look_valid,
  input logic [ADDR_W-1:0] look_addr,
  input logic              look_hit,
  input logic              act_valid,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr
);

  // R2
  rgn_start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd2 && !busy |=> busy);

  // R2
  end_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd1 && !busy |=> !busy);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !look_valid && !wb_valid && !act_valid);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && (reg_addr == 2'd2 || reg_addr == 2'd3) |=> ovr_q);

  // R8
  disable_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dis_q));

  // R8
  disable_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !act_valid && !wb_valid);

  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R10
  act_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> look_hit && look_valid);

  // R3
  look_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |-> look_addr[LINE_OFF-1:0] == '0);

endmodule

bind cache_rgn_engine cache_rgn_engine_chk #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .busy(busy),
  .dis_q(dis_q), .ovr_q(ovr_q), .look_valid(look_valid), .look_addr(look_addr),
  .look_hit(look_hit), .act_valid(act_valid), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_addr(wb_addr)
);

// File: tb/cache_rgn_engine_test.sv
module cache_rgn_engine_test;

  localparam int OFF  = 6;
  localparam int NL   = 2048;
  localparam logic [31:0] BASE = 32'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, look_addr, wb_addr;
  logic        look_valid, look_hit, look_dirty, act_valid, act_inv, wb_valid;
  logic        wb_ready = 1'b1;

  cache_rgn_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .look_valid(look_valid),
    .look_addr(look_addr), .look_hit(look_hit), .look_dirty(look_dirty),
    .act_valid(act_valid), .act_inv(act_inv), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  int total = 0, bad = 0, wb_cnt = 0, busy_cyc = 0, rdy_mode = 0;

  // environment cache state (driven by the engine's actions) and model copy
  bit ev[4096], ed[4096], mv[4096], md[4096];

  assign look_hit   = ev[(look_addr >> OFF) & 32'hFFF];
  assign look_dirty = ed[(look_addr >> OFF) & 32'hFFF];

  always @(posedge clk) begin
    if (act_valid) begin
      if (act_inv) begin
        ev[(look_addr >> OFF) & 32'hFFF] <= 1'b0;
        ed[(look_addr >> OFF) & 32'hFFF] <= 1'b0;
      end else begin
        ed[(look_addr >> OFF) & 32'hFFF] <= 1'b0;
      end
    end
    if (wb_valid && wb_ready) wb_cnt <= wb_cnt + 1;
  end

  // behavioural reference
  bit m_busy, m_dis, m_ovr, m_im, m_inv, m_fl;
  bit [2:0] m_op;
  logic [31:0] m_end;
  int unsigned m_cur, m_last;

  always @(posedge clk) begin
    bit b0, h, n;
    int unsigned ix;
    if (!rst_n) begin
      m_busy = 0; m_dis = 0; m_ovr = 0; m_im = 0; m_op = 0; m_end = 0;
      m_cur = 0; m_last = 0; m_inv = 0; m_fl = 0;
    end else begin
      b0 = m_busy;
      if (b0) begin
        ix = m_cur % 4096;
        h  = mv[ix] && !m_dis;
        n  = h && md[ix] && m_fl;
        if (!n || wb_ready) begin
          if (h && (m_inv || n)) begin
            if (m_inv) begin mv[ix] = 0; md[ix] = 0; end
            else md[ix] = 0;
          end
          if (m_cur >= m_last) m_busy = 0;
          else m_cur = m_cur + 1;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            m_op = reg_wdata[11:9]; m_im = reg_wdata[1];
            if (!b0) m_dis = reg_wdata[0];
            if (reg_wdata[3]) m_ovr = 0;
          end
          2'd1: m_end = reg_wdata;
          2'd2: if (b0) m_ovr = 1;
                else begin
                  m_busy = 1; m_cur = reg_wdata >> OFF; m_last = m_end >> OFF;
                  m_inv = (m_op == 3'b001); m_fl = (m_op != 3'b001) || m_im;
                end
          default: if (b0) m_ovr = 1;
                   else begin
                     m_busy = 1; m_cur = 0; m_last = NL - 1; m_inv = 1; m_fl = m_im;
                   end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit eh, en, ea;
    int unsigned ix;
    if (rst_n) begin
      ix = m_cur % 4096;
      eh = m_busy && mv[ix] && !m_dis;
      en = eh && md[ix] && m_fl;
      ea = eh && (m_inv || en) && (!en || wb_ready);
      chk(look_valid == m_busy, "R4", "look_valid", look_valid, m_busy);
      if (m_busy) chk(look_addr == (m_cur << OFF), "R3", "look_addr", look_addr, m_cur << OFF);
      chk(wb_valid == en, "R9", "wb_valid", wb_valid, en);
      if (en) chk(wb_addr == (m_cur << OFF), "R9", "wb_addr", wb_addr, m_cur << OFF);
      chk(act_valid == ea, "R10", "act_valid", act_valid, ea);
      if (ea) chk(act_inv == m_inv, "R1", "act_inv", act_inv, m_inv);
      if (reg_addr == 2'd0) begin
        chk(reg_rdata[2] == m_busy, "R4", "busy bit", reg_rdata[2], m_busy);
        chk(reg_rdata[3] == m_ovr, "R7", "overrun bit", reg_rdata[3], m_ovr);
        chk(reg_rdata[0] == m_dis, "R8", "disable bit", reg_rdata[0], m_dis);
      end
      if (look_valid) busy_cyc++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      wb_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom % 2);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(posedge clk);
    #2;
  endtask

  task automatic refill();
    for (int l = 256; l < 272; l++) begin
      ev[l] = (l % 3 != 0); ed[l] = (l % 3 != 0) && (l % 2 == 0);
      mv[l] = ev[l]; md[l] = ed[l];
    end
  endtask

  task automatic region(input logic [31:0] ctrl, input logic [31:0] s, input logic [31:0] e);
    wr(2'd0, ctrl);
    wr(2'd1, e);
    wr(2'd2, s);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    refill();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // reset state
    chk(reg_rdata == 32'h0, "R4", "ctrl after reset", reg_rdata, 0);
    chk(wb_valid == 1'b0, "R9", "wb_valid after reset", wb_valid, 0);

    // R2: end write only stores
    wr(2'd1, BASE + 32'h1C3);
    repeat (3) @(posedge clk);
    #2 chk(m_busy == 0 && look_valid == 0, "R2", "busy after end write", look_valid, 0);
    rd(2'd1, v);
    chk(v == BASE + 32'h1C3, "R2", "end readback", v, BASE + 32'h1C3);

    // R1/R3: flush with unaligned bounds and back-pressure
    rdy_mode = 1;
    w0 = wb_cnt;
    region(32'h0, BASE + 5, BASE + 7*64 + 3);
    chk(wb_cnt - w0 == 3, "R1", "flush write-backs", wb_cnt - w0, 3);
    chk(ev[256] == 1 && ed[256] == 0, "R1", "flushed line kept clean", {ev[256], ed[256]}, 2'b10);
    chk(ed[266] == 1, "R3", "line past end untouched", ed[266], 1);
    rd(2'd2, v);
    chk(v == BASE + 5, "R2", "start readback", v, BASE + 5);

    // R1: invalidate only
    refill(); w0 = wb_cnt;
    region(32'h200, BASE, BASE + 3*64);
    chk(wb_cnt - w0 == 0, "R1", "invalidate write-backs", wb_cnt - w0, 0);
    chk(ev[256] == 0 && ev[257] == 0, "R1", "invalidated lines", {ev[256], ev[257]}, 0);
    chk(ev[260] == 1, "R3", "line after range kept", ev[260], 1);

    // R1: flush then invalidate
    refill(); w0 = wb_cnt;
    region(32'h202, BASE + 4*64, BASE + 7*64 + 63);
    chk(wb_cnt - w0 == 2, "R1", "flush-inv write-backs", wb_cnt - w0, 2);
    chk(ev[260] == 0 && ev[263] == 0, "R1", "flush-inv dropped", {ev[260], ev[263]}, 0);

    // R1: reserved code acts as flush
    refill(); w0 = wb_cnt;
    region(32'h400, BASE, BASE);
    chk(wb_cnt - w0 == 1, "R1", "code 010 write-backs", wb_cnt - w0, 1);
    chk(ev[256] == 1 && ed[256] == 0, "R1", "code 010 keeps line", {ev[256], ed[256]}, 2'b10);

    // R3: start above end visits only the start line
    refill(); rdy_mode = 0;
    region(32'h200, BASE + 6*64 + 9, BASE + 2*64);
    chk(ev[262] == 0, "R3", "start line invalidated", ev[262], 0);
    chk(ev[263] == 1 && ev[259] == 1, "R3", "neighbours kept", {ev[263], ev[259]}, 2'b11);

    // R7: overlapping triggers are ignored and flagged
    refill(); rdy_mode = 1;
    wr(2'd0, 32'h0);
    wr(2'd1, BASE + 15*64);
    wr(2'd2, BASE);
    wr(2'd3, 32'h1);
    wr(2'd2, BASE);
    wait_idle();
    rd(2'd0, v);
    chk(v[3] == 1'b1, "R7", "overrun set", v[3], 1);
    chk(ev[257] == 1, "R7", "ignored whole-cache trigger", ev[257], 1);
    wr(2'd0, 32'h8);
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R7", "overrun cleared", v[3], 0);

    // R8: disable ignored while busy, honoured while idle
    refill(); rdy_mode = 0;
    wr(2'd0, 32'h0);
    wr(2'd2, BASE);
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd0, v);
    chk(v[0] == 1'b0, "R8", "disable write while busy", v[0], 0);
    refill(); w0 = wb_cnt;
    region(32'h203, BASE, BASE + 7*64);
    chk(ev[256] == 1 && ed[256] == 1, "R8", "disabled walk leaves line", {ev[256], ed[256]}, 2'b11);
    chk(wb_cnt - w0 == 0, "R8", "disabled write-backs", wb_cnt - w0, 0);
    wr(2'd0, 32'h0);

    // R6/R5: whole-cache invalidate with write-back first
    refill(); w0 = wb_cnt;
    wr(2'd0, 32'h2);
    busy_cyc = 0;
    wr(2'd3, 32'h1);
    wait_idle();
    chk(wb_cnt - w0 == 5, "R6", "whole-cache write-backs", wb_cnt - w0, 5);
    chk(busy_cyc == NL, "R5", "whole-cache walk length", busy_cyc, NL);
    for (int l = 256; l < 272; l++)
      chk(ev[l] == 0, "R6", "line invalidated", ev[l], 0);

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule